// File: doc/BRIEF.md
# Sector Erase Load Window Controller

This block runs the load phase of a sector erase. The command decoder sends it one pulse for each accepted sector-load write, together with the sector index. It also sends a pulse for any other command, a suspend pulse, a resume pulse and a one-microsecond tick. The first load opens an acceptance window and sets that sector's bit in a selection mask. Each further load adds its sector and restarts the window. When the window has seen no load for `WINDOW_US` ticks, the block emits a one-cycle erase-start pulse, and the erase engine works on the collected mask.

Any command other than a load or a suspend cancels a pending selection while the window is open, and the device returns to read mode. A suspend inside the window takes effect at once. A suspend during the actual erase takes effect only after `SUSP_LAT_US` ticks. A resume continues the erase. The erase engine reports completion back with `erase_done`, which clears the selection.

Top module: `sector_erase_loader`

## Requirements
- R1: After reset, `sel_mask` is 0, `win_open` is 0, `suspended` is 0, and `erase_start` and `abort_rd` are both 0.
- R2: In idle, a load with an index below `NUM_SECTORS` (11) does three things: it makes `sel_mask` one-hot, with bit k standing for sector k; it raises `win_open` on the next cycle; and it loads the window timer with `WINDOW_US` (30). A load with an index of 11 or more has no effect.
- R3: While the window is open, a valid load ORs its sector bit into `sel_mask` and reloads the timer to 30. Loading a sector that is already selected leaves `sel_mask` unchanged.
- R4: When 30 ticks arrive after the last accepted load with no further load, `win_open` drops and `erase_start` is high for exactly one cycle. Both changes appear in the cycle after the 30th tick is sampled.
- R5: A load and a tick in the same cycle count as a load. The timer is reloaded and the window stays open.
- R6: `other_req` during the window has three effects: a one-cycle `abort_rd`, `sel_mask` cleared, and a return to idle. `other_req` outside the window produces no `abort_rd`.
- R7: A suspend during the window closes it in the next cycle and raises `suspended`, and `sel_mask` is kept. If suspend and another command arrive in the same cycle, the abort of R6 wins.
- R8: While erasing, loads and other commands are ignored: `sel_mask` stays unchanged, `win_open` stays 0 and no `abort_rd` is produced.
- R9: A suspend while erasing raises `suspended` only after `SUSP_LAT_US` (100) further ticks.
- R10: A resume while suspended clears `suspended` and pulses `erase_start` for one cycle. A resume in any other state has no effect. A second suspend after a resume again obeys R9.
- R11: `erase_done` while erasing, or while waiting for a suspend to take effect, clears `sel_mask` and returns to idle. `erase_done` has no effect while suspended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_req | input | 1 | Decoded sector-load command pulse |
| load_idx | input | IDX_W (4) | Sector index for the load |
| other_req | input | 1 | Any other decoded command |
| susp_req | input | 1 | Decoded suspend command |
| resume_req | input | 1 | Decoded resume command |
| erase_done | input | 1 | Erase engine finished |
| us_tick | input | 1 | One pulse per microsecond |
| sel_mask | output | NUM_SECTORS (11) | Selected sectors |
| win_open | output | 1 | Acceptance window open (status bit 3 inverted) |
| suspended | output | 1 | Erase suspended |
| erase_start | output | 1 | One-cycle start or restart of erase |
| abort_rd | output | 1 | One-cycle abort back to read mode |

## Verification
Two pairs of functions can fall in the same cycle: a load can coincide with the tick that would close the window, and a suspend can coincide with another command while the window is open. Both pairs are provoked by driving the two inputs together on chosen cycles. For the first pair, the load is placed exactly on the 30th tick after the previous load. The reference model in the bench decides the winner from the stated priorities. The design is judged on the next cycle by whether the window is still open, and by whether `abort_rd` or `suspended` rose.

// File: rtl/sel_erase_pkg.sv
package sel_erase_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WINDOW,
    ST_ERASING,
    ST_SUSP_WAIT,
    ST_SUSPENDED
  } ld_state_t;

  // one-hot selection bit for a sector index (caller slices to its width)
  function automatic logic [31:0] sector_bit(input logic [31:0] idx);
    return 32'd1 << idx[4:0];
  endfunction

endpackage

// File: rtl/us_countdown.sv
module us_countdown #(
  parameter int unsigned RELOAD = 30
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic load,
  input  logic tick,
  output logic expire
);
  localparam int W = $clog2(RELOAD + 1);

  logic [W-1:0] count;

  always_ff @(posedge clk) begin
    if (!rst_n)                             count <= '0;
    else if (load)                          count <= W'(RELOAD);
    else if (run && tick && count != '0)    count <= count - 1'b1;
  end

  // a load in the same cycle wins over the final tick
  assign expire = run && tick && !load && (count == W'(1));
endmodule

// File: rtl/sel_mask_reg.sv
module sel_mask_reg #(
  parameter int N     = 11,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic [IDX_W-1:0] idx,
  input  logic             clr,
  output logic [N-1:0]     mask
);
  import sel_erase_pkg::*;

  logic [31:0] full_bit;
  assign full_bit = sector_bit(32'(idx));

  always_ff @(posedge clk) begin
    if (!rst_n)      mask <= '0;
    else if (clr)    mask <= '0;
    else if (set_en) mask <= mask | full_bit[N-1:0];
  end
endmodule

// File: rtl/sector_erase_loader.sv
module sector_erase_loader #(
  parameter int NUM_SECTORS = 11,
  parameter int WINDOW_US   = 30,
  parameter int SUSP_LAT_US = 100,
  localparam int IDX_W      = $clog2(NUM_SECTORS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load_req,
  input  logic [IDX_W-1:0]       load_idx,
  input  logic                   other_req,
  input  logic                   susp_req,
  input  logic                   resume_req,
  input  logic                   erase_done,
  input  logic                   us_tick,
  output logic [NUM_SECTORS-1:0] sel_mask,
  output logic                   win_open,
  output logic                   suspended,
  output logic                   erase_start,
  output logic                   abort_rd
);
  import sel_erase_pkg::*;

  ld_state_t state, state_nx;

  logic in_idle, in_win, in_erase, in_swait, in_susp;
  assign in_idle  = (state == ST_IDLE);
  assign in_win   = (state == ST_WINDOW);
  assign in_erase = (state == ST_ERASING);
  assign in_swait = (state == ST_SUSP_WAIT);
  assign in_susp  = (state == ST_SUSPENDED);

  // named events, also visible to the checker
  logic idx_ok, accept_load, abort_ev, susp_now, win_exp, expire_ev;
  logic slow_susp, lat_exp, lat_done, resume_ev, finish_ev;

  assign idx_ok      = (32'(load_idx) < NUM_SECTORS);
  assign abort_ev    = in_win && other_req;
  assign susp_now    = in_win && susp_req && !other_req;
  assign accept_load = load_req && idx_ok &&
                       (in_idle || (in_win && !other_req && !susp_req));
  assign expire_ev   = win_exp && !other_req && !susp_req;
  assign finish_ev   = (in_erase || in_swait) && erase_done;
  assign slow_susp   = in_erase && susp_req && !erase_done;
  assign lat_done    = lat_exp && !erase_done;
  assign resume_ev   = in_susp && resume_req;

  us_countdown #(.RELOAD(WINDOW_US)) u_win_tmr (
    .clk(clk), .rst_n(rst_n), .run(in_win), .load(accept_load),
    .tick(us_tick), .expire(win_exp)
  );

  us_countdown #(.RELOAD(SUSP_LAT_US)) u_lat_tmr (
    .clk(clk), .rst_n(rst_n), .run(in_swait), .load(slow_susp),
    .tick(us_tick), .expire(lat_exp)
  );

  sel_mask_reg #(.N(NUM_SECTORS), .IDX_W(IDX_W)) u_mask (
    .clk(clk), .rst_n(rst_n), .set_en(accept_load), .idx(load_idx),
    .clr(abort_ev || finish_ev), .mask(sel_mask)
  );

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE:      if (accept_load) state_nx = ST_WINDOW;
      ST_WINDOW: begin
        if (abort_ev)       state_nx = ST_IDLE;
        else if (susp_now)  state_nx = ST_SUSPENDED;
        else if (expire_ev) state_nx = ST_ERASING;
      end
      ST_ERASING: begin
        if (finish_ev)      state_nx = ST_IDLE;
        else if (slow_susp) state_nx = ST_SUSP_WAIT;
      end
      ST_SUSP_WAIT: begin
        if (finish_ev)      state_nx = ST_IDLE;
        else if (lat_done)  state_nx = ST_SUSPENDED;
      end
      ST_SUSPENDED: if (resume_ev) state_nx = ST_ERASING;
      default:      state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      erase_start <= 1'b0;
      abort_rd    <= 1'b0;
    end else begin
      state       <= state_nx;
      erase_start <= expire_ev || resume_ev;
      abort_rd    <= abort_ev;
    end
  end

  assign win_open  = in_win;
  assign suspended = in_susp;
endmodule

// File: rtl/sel_erase_chk.sv
module sel_erase_chk #(
  parameter int N = 11
) (
  input logic         clk,
  input logic         rst_n,
  input logic         other_req,
  input logic         susp_req,
  input logic         load_ev,
  input logic [N-1:0] sel_mask,
  input logic         win_open,
  input logic         suspended,
  input logic         erase_start,
  input logic         abort_rd
);
  p_window_nonempty_r2: assert property (@(posedge clk) disable iff (!rst_n)
    win_open |-> sel_mask != '0);

  p_load_opens_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load_ev |=> win_open);

  p_start_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |-> ($past(win_open) || $past(suspended)));

  p_other_aborts_r6: assert property (@(posedge clk) disable iff (!rst_n)
    win_open && other_req |=> abort_rd && sel_mask == '0 && !win_open);

  p_pulses_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({erase_start, abort_rd}));

  p_fast_suspend_r7: assert property (@(posedge clk) disable iff (!rst_n)
    win_open && susp_req && !other_req |=> suspended && !win_open);

  p_suspend_holds_mask_r11: assert property (@(posedge clk) disable iff (!rst_n)
    suspended |=> $stable(sel_mask));

  p_modes_disjoint_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(win_open && suspended));
endmodule

bind sector_erase_loader sel_erase_chk #(.N(NUM_SECTORS)) u_chk (
  .clk(clk), .rst_n(rst_n), .other_req(other_req), .susp_req(susp_req),
  .load_ev(accept_load), .sel_mask(sel_mask), .win_open(win_open),
  .suspended(suspended), .erase_start(erase_start), .abort_rd(abort_rd)
);

// File: tb/sector_erase_loader_test.sv
`timescale 1ns/1ps
module sector_erase_loader_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load_req = 0, other_req = 0, susp_req = 0, resume_req = 0;
  logic erase_done = 0, us_tick = 0;
  logic [3:0]  load_idx = 0;
  logic [10:0] sel_mask;
  logic win_open, suspended, erase_start, abort_rd;

  int total = 0;
  int bad   = 0;

  // reference model state: 0 idle, 1 window, 2 erasing, 3 suspend wait, 4 suspended
  int m_st = 0, m_mask = 0, m_tmr = 0, m_lat = 0, m_start = 0, m_abort = 0;

  always #2.5 clk = ~clk;

  sector_erase_loader uut (
    .clk(clk), .rst_n(rst_n), .load_req(load_req), .load_idx(load_idx),
    .other_req(other_req), .susp_req(susp_req), .resume_req(resume_req),
    .erase_done(erase_done), .us_tick(us_tick), .sel_mask(sel_mask),
    .win_open(win_open), .suspended(suspended), .erase_start(erase_start),
    .abort_rd(abort_rd)
  );

  task automatic compare(input string tag);
    int got, exp;
    got = {sel_mask, win_open, suspended, erase_start, abort_rd};
    exp = (m_mask << 4) | ((m_st == 1) << 3) | ((m_st == 4) << 2) | (m_start << 1) | m_abort;
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got mask=%h win=%0d susp=%0d start=%0d abort=%0d, expected mask=%h win=%0d susp=%0d start=%0d abort=%0d",
               tag, sel_mask, win_open, suspended, erase_start, abort_rd,
               m_mask, m_st == 1, m_st == 4, m_start, m_abort);
    end
  endtask

  task automatic step(input bit ld, input int idx, input bit oth, input bit sp,
                      input bit rs, input bit dn, input bit tk, input string tag);
    load_req = ld; load_idx = 4'(idx); other_req = oth; susp_req = sp;
    resume_req = rs; erase_done = dn; us_tick = tk;
    m_start = 0; m_abort = 0;
    case (m_st)
      0: if (ld && idx < 11) begin m_mask = 1 << idx; m_tmr = 30; m_st = 1; end
      1: begin
        if (oth) begin m_abort = 1; m_mask = 0; m_st = 0; end
        else if (sp) m_st = 4;
        else if (ld && idx < 11) begin m_mask = m_mask | (1 << idx); m_tmr = 30; end
        else if (tk) begin
          m_tmr = m_tmr - 1;
          if (m_tmr == 0) begin m_st = 2; m_start = 1; end
        end
      end
      2: begin
        if (dn) begin m_mask = 0; m_st = 0; end
        else if (sp) begin m_st = 3; m_lat = 100; end
      end
      3: begin
        if (dn) begin m_mask = 0; m_st = 0; end
        else if (tk) begin
          m_lat = m_lat - 1;
          if (m_lat == 0) m_st = 4;
        end
      end
      4: if (rs) begin m_st = 2; m_start = 1; end
      default: m_st = 0;
    endcase
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic ticks(input int n, input string tag);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 1, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: got hang, expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    compare("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1 after reset");

    // R2: out-of-range index ignored, then valid first load
    step(1, 13, 0, 0, 0, 0, 0, "R2 bad index");
    step(1, 3, 0, 0, 0, 0, 0, "R2 first load");
    // R3: further loads and duplicate
    step(1, 5, 0, 0, 0, 0, 1, "R3 add sector");
    step(1, 5, 0, 0, 0, 0, 1, "R3 duplicate");
    ticks(10, "R3 ticking");
    step(1, 0, 0, 0, 0, 0, 0, "R3 add sector 0");
    // R5: load together with the expiring tick
    ticks(29, "R5 run up");
    step(1, 10, 0, 0, 0, 0, 1, "R5 load on last tick");
    // R4: expiry
    ticks(30, "R4 expiry");
    step(0, 0, 0, 0, 0, 0, 0, "R4 pulse ends");
    // R8: ignored while erasing
    step(1, 7, 0, 0, 0, 0, 0, "R8 load ignored");
    step(0, 0, 1, 0, 0, 0, 0, "R8 other ignored");
    step(0, 0, 0, 0, 1, 0, 0, "R10 resume ignored");
    // R9: slow suspend
    step(0, 0, 0, 1, 0, 0, 0, "R9 suspend issued");
    ticks(100, "R9 latency");
    // R11: done ignored while suspended
    step(0, 0, 0, 0, 0, 1, 0, "R11 done ignored");
    step(1, 2, 1, 0, 0, 0, 0, "R8 suspended ignores");
    // R10: resume and second suspend
    step(0, 0, 0, 0, 1, 0, 0, "R10 resume");
    step(0, 0, 0, 1, 0, 0, 1, "R10 second suspend");
    ticks(100, "R10 second latency");
    step(0, 0, 0, 0, 1, 0, 0, "R10 resume again");
    step(0, 0, 0, 0, 0, 1, 0, "R11 done clears");
    // R6: abort and ignored other command
    step(0, 0, 1, 0, 0, 0, 0, "R6 other in idle");
    step(1, 2, 0, 0, 0, 0, 0, "R6 open");
    ticks(5, "R6 ticking");
    step(0, 0, 1, 0, 0, 0, 1, "R6 abort");
    step(0, 0, 0, 0, 0, 0, 0, "R6 pulse ends");
    // R7: suspend with other command, then plain fast suspend
    step(1, 9, 0, 0, 0, 0, 0, "R7 open");
    step(1, 4, 1, 1, 0, 0, 0, "R7 abort wins");
    step(1, 9, 0, 0, 0, 0, 0, "R7 reopen");
    step(1, 4, 0, 1, 0, 0, 0, "R7 fast suspend");
    step(0, 0, 0, 0, 1, 0, 0, "R10 resume from window suspend");
    // R11: done during suspend wait
    step(0, 0, 0, 1, 0, 0, 1, "R11 suspend wait");
    ticks(40, "R11 wait ticks");
    step(0, 0, 0, 0, 0, 1, 1, "R11 done in wait");
    step(0, 0, 0, 0, 0, 0, 0, "R1 idle again");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule